// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the instruction fetch address for a small 4-bit controller. The 11-bit address is made of a 1-bit block register, a 4-bit page register and a 6-bit word counter. The word counter moves forward on each fetch and wraps inside the current page. Block and page change only through a taken jump, a return or a table read. A jump takes its new block and page from two buffer registers that software loads beforehand. A jump therefore needs two steps: load the buffer, then branch or call.

Calls and table reads save their return point on a three-level shift stack. The stack has no pointer: a push moves every level down one place, and a pop moves every level up one place. On a pop the deepest level keeps its value, so it is duplicated. A small depth counter tracks how many levels are in use. A push made while all three levels are full raises a one-cycle reset request.

A table read jumps to an address built from the X, A and Y values. On the following cycle it captures the fetched byte, hands it back as two nibbles, and returns to the instruction after the read.

Top module: `prg_seq_top`

## Requirements
- R1: After reset, `rom_addr_o` is 0, `tbl_valid_o` is 0 and `stack_ovf_rst_o` is 0. The block register, the page register, both buffers, the word counter and all stack levels are 0.
- R2: `rom_addr_o` is {block, page, word}: bit 10 is the block, bits 9:6 the page and bits 5:0 the word. A step adds 1 to the word modulo 64 and leaves page and block unchanged, so execution wraps inside the page.
- R3: `ld_pb_i` loads the page buffer from `imm_i`, and `ld_bb_i` loads the block buffer from `y_i[0]`. Neither load changes `rom_addr_o`. A jump taken in the same cycle as a load still uses the old buffer value. The new value takes effect on the next taken jump.
- R4: A branch with `st_i`=1 sets block to the block buffer, page to the page buffer and word to `target_i`. A branch with `st_i`=0 behaves as a step.
- R5: A call with `st_i`=1 makes the same jump as a taken branch. It also pushes {block, page, word+1} into level 1, while level 1 moves to level 2 and level 2 moves to level 3. A call with `st_i`=0 behaves as a step and pushes nothing.
- R6: A return loads block, page and word from level 1. It also copies the restored page into the page buffer and the restored block into the block buffer. Level 2 moves to level 1, level 3 moves to level 2, and level 3 keeps its value.
- R7: `st_o` is 1 in any cycle whose selected operation is a branch, call or return, whether or not the jump is taken. In every other cycle `st_o` equals `st_i`.
- R8: A table read pushes {block, page, word+1}. On the next cycle `rom_addr_o` keeps the block and takes page = {x_i, a_i[3:2]} and word = {a_i[1:0], y_i}. During that fetch cycle all strobes are ignored. At the end of the fetch cycle `rom_data_i[7:4]` goes to `tbl_a_o` and `rom_data_i[3:0]` goes to `tbl_y_o`. On the cycle after, `tbl_valid_o` is high for one cycle. The stack is popped into block, page and word, the page buffer takes the restored page, and the block buffer is left unchanged.
- R9: The depth counter counts occupied levels, up to 3. A push made when 3 levels are occupied raises `stack_ovf_rst_o` on the next cycle for one cycle, and the depth stays at 3. A pop at depth 0 keeps the depth at 0.
- R10: When several operation strobes are high together, one operation is selected in this priority order: table read, return, call, branch, step. The buffer loads act independently of this choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| step_i | input | 1 | Advance the word counter |
| br_i | input | 1 | Conditional branch |
| cal_i | input | 1 | Conditional call |
| rtn_i | input | 1 | Return |
| ld_pb_i | input | 1 | Load page buffer from `imm_i` |
| ld_bb_i | input | 1 | Load block buffer from `y_i[0]` |
| tbl_i | input | 1 | Start a table read |
| target_i | input | 6 | Jump target word |
| imm_i | input | 4 | Page immediate |
| st_i | input | 1 | Current status flag |
| x_i | input | 2 | X register value |
| a_i | input | 4 | Accumulator value |
| y_i | input | 4 | Y register value |
| rom_data_i | input | 8 | Byte fetched at `rom_addr_o` |
| rom_addr_o | output | 11 | Program memory address |
| st_o | output | 1 | Updated status |
| tbl_a_o | output | 4 | High nibble from a table read |
| tbl_y_o | output | 4 | Low nibble from a table read |
| tbl_valid_o | output | 1 | Table result valid pulse |
| stack_ovf_rst_o | output | 1 | Stack overflow reset request |

## Verification
A long run of steps separates a counter that wraps inside the page from one that carries into the page field. Buffer loads with no jump, and loads placed in the same cycle as a taken jump, show whether buffers drive the address too early. Four nested calls followed by more returns than pushes exercise the overflow pulse, the duplication of the deepest level and the return at depth 0. Random mixes of strobes, status values and X/A/Y values, including table reads with strobes held high during the fetch cycle, check priority and the ignore rule against a reference model kept in the bench.

// File: rtl/prg_seq_pkg.sv
`timescale 1ns/1ps
package prg_seq_pkg;

  // Operation chosen for the current cycle after priority resolution.
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_STEP = 3'd1,
    OP_BR   = 3'd2,
    OP_CAL  = 3'd3,
    OP_RTN  = 3'd4,
    OP_TBL  = 3'd5
  } seq_op_e;

  localparam int unsigned DEF_WORD_W  = 6;
  localparam int unsigned DEF_PAGE_W  = 4;
  localparam int unsigned DEF_BLOCK_W = 1;
  localparam int unsigned DEF_NIB_W   = 4;
  localparam int unsigned DEF_LEVELS  = 3;

endpackage

// File: rtl/prg_seq_decode.sv
`timescale 1ns/1ps
module prg_seq_decode
  import prg_seq_pkg::*;
(
  input  logic    fetch_i,
  input  logic    tbl_i,
  input  logic    rtn_i,
  input  logic    cal_i,
  input  logic    br_i,
  input  logic    step_i,
  output seq_op_e op_o
);

  // Fixed priority: table read, return, call, branch, step (R10).
  // Nothing is selected while a table fetch cycle is in progress (R8).
  always_comb begin
    if (fetch_i)     op_o = OP_IDLE;
    else if (tbl_i)  op_o = OP_TBL;
    else if (rtn_i)  op_o = OP_RTN;
    else if (cal_i)  op_o = OP_CAL;
    else if (br_i)   op_o = OP_BR;
    else if (step_i) op_o = OP_STEP;
    else             op_o = OP_IDLE;
  end

  always_comb begin
    assert_fetch_idle_R8: assert (!fetch_i || op_o == OP_IDLE)
      else $error("operation selected during table fetch");
  end

endmodule

// File: rtl/prg_seq_stack.sv
`timescale 1ns/1ps
module prg_seq_stack #(
  parameter int unsigned LEVELS  = prg_seq_pkg::DEF_LEVELS,
  parameter int unsigned ENTRY_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [ENTRY_W-1:0]         push_data_i,
  output logic [ENTRY_W-1:0]         top_o,
  output logic [$clog2(LEVELS+1)-1:0] depth_o,
  output logic                       ovf_o
);

  localparam int unsigned CNT_W = $clog2(LEVELS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LEVELS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [ENTRY_W-1:0] lvl_q [LEVELS];
  logic [CNT_W-1:0]   cnt_q;
  logic               ovf_q;
  logic               full_w;

  assign full_w = (cnt_q == CNT_FULL);

  // Shift levels: push moves down, pop moves up, deepest level held on pop.
  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    logic [ENTRY_W-1:0] from_above;
    logic [ENTRY_W-1:0] from_below;
    if (k == 0) begin : g_head
      assign from_above = push_data_i;
    end else begin : g_body
      assign from_above = lvl_q[k-1];
    end
    if (k == LEVELS - 1) begin : g_tail
      assign from_below = lvl_q[k];
    end else begin : g_mid
      assign from_below = lvl_q[k+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q[k] <= '0;
      else if (push_i) lvl_q[k] <= from_above;
      else if (pop_i)  lvl_q[k] <= from_below;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= push_i && full_w;
      if (push_i && !full_w)                   cnt_q <= cnt_q + CNT_ONE;
      else if (pop_i && !push_i && cnt_q != 0) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign top_o   = lvl_q[0];
  assign depth_o = cnt_q;
  assign ovf_o   = ovf_q;

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL)
    else $error("stack depth beyond capacity");

  assert_ovf_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> full_w)
    else $error("overflow pulse without a full stack");

  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_w) |=> ovf_q)
    else $error("push at full depth did not raise overflow");

endmodule

// File: rtl/prg_seq_top.sv
`timescale 1ns/1ps
module prg_seq_top
  import prg_seq_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned PAGE_W  = DEF_PAGE_W,
  parameter int unsigned BLOCK_W = DEF_BLOCK_W,
  parameter int unsigned NIB_W   = DEF_NIB_W,
  parameter int unsigned LEVELS  = DEF_LEVELS,
  localparam int unsigned ADDR_W = BLOCK_W + PAGE_W + WORD_W,
  localparam int unsigned X_W    = PAGE_W + WORD_W - 2 * NIB_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                br_i,
  input  logic                cal_i,
  input  logic                rtn_i,
  input  logic                ld_pb_i,
  input  logic                ld_bb_i,
  input  logic                tbl_i,
  input  logic [WORD_W-1:0]   target_i,
  input  logic [PAGE_W-1:0]   imm_i,
  input  logic                st_i,
  input  logic [X_W-1:0]      x_i,
  input  logic [NIB_W-1:0]    a_i,
  input  logic [NIB_W-1:0]    y_i,
  input  logic [2*NIB_W-1:0]  rom_data_i,
  output logic [ADDR_W-1:0]   rom_addr_o,
  output logic                st_o,
  output logic [NIB_W-1:0]    tbl_a_o,
  output logic [NIB_W-1:0]    tbl_y_o,
  output logic                tbl_valid_o,
  output logic                stack_ovf_rst_o
);

  localparam int unsigned PW_HI = PAGE_W + WORD_W;
  localparam logic [WORD_W-1:0] WORD_ONE = WORD_W'(1);

  // Arithmetic kept in functions so the bench can restate it separately.
  function automatic logic [WORD_W-1:0] word_inc(input logic [WORD_W-1:0] w);
    return w + WORD_ONE;
  endfunction

  function automatic logic [PW_HI-1:0] table_ptr(input logic [X_W-1:0] x,
                                                 input logic [NIB_W-1:0] a,
                                                 input logic [NIB_W-1:0] y);
    return {x, a, y};
  endfunction

  logic [WORD_W-1:0]  word_q;
  logic [PAGE_W-1:0]  page_q;
  logic [BLOCK_W-1:0] blk_q;
  logic [PAGE_W-1:0]  pg_buf_q;
  logic [BLOCK_W-1:0] blk_buf_q;
  logic               fetch_q;
  logic [NIB_W-1:0]   tbl_a_q;
  logic [NIB_W-1:0]   tbl_y_q;
  logic               tbl_valid_q;

  seq_op_e            op_w;
  logic               taken_w;
  logic               push_w;
  logic               pop_w;
  logic [ADDR_W-1:0]  push_data_w;
  logic [ADDR_W-1:0]  stk_top_w;
  logic [$clog2(LEVELS+1)-1:0] stk_depth_w;
  logic               stk_ovf_w;

  logic [WORD_W-1:0]  top_word_w;
  logic [PAGE_W-1:0]  top_page_w;
  logic [BLOCK_W-1:0] top_blk_w;
  logic [PW_HI-1:0]   tbl_ptr_w;

  prg_seq_decode u_decode (
    .fetch_i (fetch_q),
    .tbl_i   (tbl_i),
    .rtn_i   (rtn_i),
    .cal_i   (cal_i),
    .br_i    (br_i),
    .step_i  (step_i),
    .op_o    (op_w)
  );

  assign taken_w     = st_i && (op_w == OP_BR || op_w == OP_CAL);
  assign push_w      = (op_w == OP_CAL && st_i) || (op_w == OP_TBL);
  assign pop_w       = (op_w == OP_RTN) || fetch_q;
  assign push_data_w = {blk_q, page_q, word_inc(word_q)};

  prg_seq_stack #(
    .LEVELS  (LEVELS),
    .ENTRY_W (ADDR_W)
  ) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_w),
    .pop_i       (pop_w),
    .push_data_i (push_data_w),
    .top_o       (stk_top_w),
    .depth_o     (stk_depth_w),
    .ovf_o       (stk_ovf_w)
  );

  assign top_word_w = stk_top_w[WORD_W-1:0];
  assign top_page_w = stk_top_w[PW_HI-1:WORD_W];
  assign top_blk_w  = stk_top_w[ADDR_W-1:PW_HI];
  assign tbl_ptr_w  = table_ptr(x_i, a_i, y_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= '0;
      page_q      <= '0;
      blk_q       <= '0;
      pg_buf_q    <= '0;
      blk_buf_q   <= '0;
      fetch_q     <= 1'b0;
      tbl_a_q     <= '0;
      tbl_y_q     <= '0;
      tbl_valid_q <= 1'b0;
    end else if (fetch_q) begin
      // Second cycle of a table read: capture data, return to caller.
      fetch_q     <= 1'b0;
      tbl_a_q     <= rom_data_i[2*NIB_W-1:NIB_W];
      tbl_y_q     <= rom_data_i[NIB_W-1:0];
      tbl_valid_q <= 1'b1;
      word_q      <= top_word_w;
      page_q      <= top_page_w;
      pg_buf_q    <= top_page_w;
      blk_q       <= top_blk_w;
    end else begin
      tbl_valid_q <= 1'b0;
      if (ld_pb_i) pg_buf_q  <= imm_i;
      if (ld_bb_i) blk_buf_q <= y_i[BLOCK_W-1:0];
      unique case (op_w)
        OP_STEP: word_q <= word_inc(word_q);
        OP_BR, OP_CAL: begin
          if (taken_w) begin
            word_q <= target_i;
            page_q <= pg_buf_q;
            blk_q  <= blk_buf_q;
          end else begin
            word_q <= word_inc(word_q);
          end
        end
        OP_RTN: begin
          word_q    <= top_word_w;
          page_q    <= top_page_w;
          pg_buf_q  <= top_page_w;
          blk_q     <= top_blk_w;
          blk_buf_q <= top_blk_w;
        end
        OP_TBL: begin
          word_q  <= tbl_ptr_w[WORD_W-1:0];
          page_q  <= tbl_ptr_w[PW_HI-1:WORD_W];
          fetch_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rom_addr_o      = {blk_q, page_q, word_q};
  assign st_o            = (op_w == OP_BR || op_w == OP_CAL || op_w == OP_RTN) ? 1'b1 : st_i;
  assign tbl_a_o         = tbl_a_q;
  assign tbl_y_o         = tbl_y_q;
  assign tbl_valid_o     = tbl_valid_q;
  assign stack_ovf_rst_o = stk_ovf_w;

  // ---------------- assertions ----------------
  assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_STEP) |=> (word_q == WORD_W'($past(word_q) + 1)) && $stable(page_q) && $stable(blk_q))
    else $error("step did not advance within page");

  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_q && (op_w == OP_IDLE || op_w == OP_STEP ||
                  ((op_w == OP_BR || op_w == OP_CAL) && !st_i)))
    |=> $stable(page_q) && $stable(blk_q))
    else $error("page or block moved without a jump");

  assert_ret_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_RTN) |=> (rom_addr_o == $past(stk_top_w)) && (pg_buf_q == page_q))
    else $error("return did not restore level 1");

  assert_status_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_q && (br_i || cal_i || rtn_i) && !tbl_i) |-> st_o)
    else $error("status not forced on branch, call or return");

  assert_tbl_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_TBL) |=> fetch_q && (rom_addr_o[PW_HI-1:0] == $past(tbl_ptr_w)))
    else $error("table read did not address the table");

  assert_tbl_leave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |=> !fetch_q && tbl_valid_q)
    else $error("table fetch did not complete in one cycle");

  assert_ovf_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf_rst_o |-> (stk_depth_w == ($clog2(LEVELS+1))'(LEVELS)))
    else $error("overflow request with stack not full");

endmodule

// File: tb/prg_seq_top_tb.sv
`timescale 1ns/1ps
module prg_seq_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic step_i = 0, br_i = 0, cal_i = 0, rtn_i = 0, ld_pb_i = 0, ld_bb_i = 0, tbl_i = 0;
  logic [5:0] target_i = '0;
  logic [3:0] imm_i = '0;
  logic st_i = 0;
  logic [1:0] x_i = '0;
  logic [3:0] a_i = '0;
  logic [3:0] y_i = '0;
  logic [7:0] rom_data_i;
  logic [10:0] rom_addr_o;
  logic st_o;
  logic [3:0] tbl_a_o, tbl_y_o;
  logic tbl_valid_o, stack_ovf_rst_o;

  function automatic logic [7:0] rom_byte(input logic [10:0] ad);
    return ad[7:0] ^ {ad[10:8], 5'b10101};
  endfunction

  assign rom_data_i = rom_byte(rom_addr_o);

  prg_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .br_i(br_i), .cal_i(cal_i),
    .rtn_i(rtn_i), .ld_pb_i(ld_pb_i), .ld_bb_i(ld_bb_i), .tbl_i(tbl_i),
    .target_i(target_i), .imm_i(imm_i), .st_i(st_i), .x_i(x_i), .a_i(a_i),
    .y_i(y_i), .rom_data_i(rom_data_i), .rom_addr_o(rom_addr_o), .st_o(st_o),
    .tbl_a_o(tbl_a_o), .tbl_y_o(tbl_y_o), .tbl_valid_o(tbl_valid_o),
    .stack_ovf_rst_o(stack_ovf_rst_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  logic       m_blk, m_bb;
  logic [3:0] m_pg, m_pb;
  logic [5:0] m_wd;
  logic [10:0] ms [3];
  int         md;
  logic       m_fetch, m_tv, m_ovf;
  logic [3:0] m_ta, m_ty;

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] nxt(input logic [5:0] w);
    return 6'(w + 6'd1);
  endfunction

  task automatic m_push(input logic [10:0] e);
    m_ovf = (md == 3);
    if (md < 3) md++;
    ms[2] = ms[1]; ms[1] = ms[0]; ms[0] = e;
  endtask

  task automatic m_pop(output logic [10:0] e);
    e = ms[0];
    ms[0] = ms[1]; ms[1] = ms[2];
    if (md > 0) md--;
  endtask

  task automatic run_op(input bit stp, input bit br, input bit cal, input bit rtn,
                        input bit lpb, input bit lbb, input bit tbl,
                        input logic [5:0] tgt, input logic [3:0] imm, input bit st,
                        input logic [1:0] x, input logic [3:0] a, input logic [3:0] y,
                        input string hint);
    string tag;
    logic [10:0] e;
    logic [7:0] by;
    logic old_bb;
    logic [3:0] old_pb;
    logic exp_st;
    step_i = stp; br_i = br; cal_i = cal; rtn_i = rtn; ld_pb_i = lpb; ld_bb_i = lbb;
    tbl_i = tbl; target_i = tgt; imm_i = imm; st_i = st; x_i = x; a_i = a; y_i = y;
    #2;
    exp_st = (!m_fetch && !tbl && (rtn || cal || br)) ? 1'b1 : st;
    check("R7", "st_o", 16'(st_o), 16'(exp_st));
    m_ovf = 0;
    if (m_fetch) begin
      by = rom_byte({m_blk, m_pg, m_wd});
      m_ta = by[7:4]; m_ty = by[3:0]; m_tv = 1; m_fetch = 0;
      m_pop(e);
      m_blk = e[10]; m_pg = e[9:6]; m_pb = e[9:6]; m_wd = e[5:0];
      tag = "R8";
    end else begin
      m_tv = 0;
      old_bb = m_bb; old_pb = m_pb;
      if (lpb) m_pb = imm;
      if (lbb) m_bb = y[0];
      if (tbl) begin
        m_push({m_blk, m_pg, nxt(m_wd)});
        {m_pg, m_wd} = {x, a, y};
        m_fetch = 1; tag = "R8";
      end else if (rtn) begin
        m_pop(e);
        m_blk = e[10]; m_bb = e[10]; m_pg = e[9:6]; m_pb = e[9:6]; m_wd = e[5:0];
        tag = "R6";
      end else if (cal) begin
        if (st) begin
          m_push({m_blk, m_pg, nxt(m_wd)});
          m_blk = old_bb; m_pg = old_pb; m_wd = tgt;
        end else m_wd = nxt(m_wd);
        tag = "R5";
      end else if (br) begin
        if (st) begin m_blk = old_bb; m_pg = old_pb; m_wd = tgt; end
        else m_wd = nxt(m_wd);
        tag = "R4";
      end else if (stp) begin
        m_wd = nxt(m_wd); tag = "R2";
      end else tag = "R3";
    end
    if (hint != "") tag = hint;
    @(posedge clk);
    @(negedge clk);
    check(tag, "rom_addr_o", 16'(rom_addr_o), 16'({m_blk, m_pg, m_wd}));
    check("R9", "stack_ovf_rst_o", 16'(stack_ovf_rst_o), 16'(m_ovf));
    check("R8", "tbl_valid_o", 16'(tbl_valid_o), 16'(m_tv));
    if (m_tv) begin
      check("R8", "tbl_a_o", 16'(tbl_a_o), 16'(m_ta));
      check("R8", "tbl_y_o", 16'(tbl_y_o), 16'(m_ty));
    end
  endtask

  task automatic idle_op(input string hint);
    run_op(0,0,0,0,0,0,0, 6'd0, 4'd0, 0, 2'd0, 4'd0, 4'd0, hint);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_blk = 0; m_bb = 0; m_pg = 0; m_pb = 0; m_wd = 0; md = 0;
    m_fetch = 0; m_tv = 0; m_ovf = 0; m_ta = 0; m_ty = 0;
    for (int i = 0; i < 3; i++) ms[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "rom_addr_o", 16'(rom_addr_o), 16'd0);
    check("R1", "tbl_valid_o", 16'(tbl_valid_o), 16'd0);
    check("R1", "stack_ovf_rst_o", 16'(stack_ovf_rst_o), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: wrap within page over 70 steps
    for (int i = 0; i < 70; i++) run_op(1,0,0,0,0,0,0, 6'd0, 4'd0, 0, 2'd0, 4'd0, 4'd0, "R2");

    // R3: buffer loads do not move execution; jump in same cycle uses old buffer
    run_op(0,0,0,0,1,1,0, 6'd0, 4'd9, 0, 2'd0, 4'd0, 4'd1, "R3");
    run_op(1,0,0,0,0,0,0, 6'd0, 4'd0, 0, 2'd0, 4'd0, 4'd0, "R3");
    run_op(0,1,0,0,1,1,0, 6'd17, 4'd3, 1, 2'd0, 4'd0, 4'd0, "R3");
    run_op(0,1,0,0,0,0,0, 6'd40, 4'd0, 1, 2'd0, 4'd0, 4'd0, "R4");
    run_op(0,1,0,0,0,0,0, 6'd2, 4'd0, 0, 2'd0, 4'd0, 4'd0, "R4");

    // R9: four nested calls overflow, then over-popping
    for (int i = 0; i < 4; i++)
      run_op(0,0,1,0,1,0,0, 6'(i * 5 + 1), 4'(i + 2), 1, 2'd0, 4'd0, 4'd0, "");
    for (int i = 0; i < 5; i++)
      run_op(0,0,0,1,0,0,0, 6'd0, 4'd0, 0, 2'd0, 4'd0, 4'd0, "R6");
    run_op(0,0,1,0,0,0,0, 6'd9, 4'd0, 0, 2'd0, 4'd0, 4'd0, "R5");

    // R8: table read with strobes held during fetch
    run_op(0,0,0,0,0,0,1, 6'd0, 4'd0, 0, 2'd2, 4'd13, 4'd6, "R8");
    run_op(1,1,1,1,1,1,1, 6'd33, 4'd7, 1, 2'd1, 4'd1, 4'd1, "R8");
    idle_op("R8");

    // R10: priority among simultaneous strobes
    run_op(1,1,1,0,0,0,0, 6'd12, 4'd0, 1, 2'd0, 4'd0, 4'd0, "R10");
    run_op(1,1,1,1,0,0,0, 6'd12, 4'd0, 1, 2'd0, 4'd0, 4'd0, "R10");

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned k;
      bit s, b, c, r, t, lp, lb;
      k = $urandom % 16;
      s = (k < 6); b = (k >= 6 && k < 9); c = (k == 9 || k == 10);
      r = (k == 11 || k == 12); t = (k == 13);
      lp = ($urandom % 4) == 0; lb = ($urandom % 4) == 0;
      run_op(s, b, c, r, lp, lb, t, 6'($urandom), 4'($urandom), 1'($urandom),
             2'($urandom), 4'($urandom), 4'($urandom), "");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule